// File: doc/BRIEF.md
# Clock Select and Divide Update Controller

This block derives clock-enable pulses for five clock domains (CPU, cache, bus 0, bus 2 and peripheral bus) from two source clocks, each represented as an enable strobe on a fast reference clock. A first-level select picks the shared system clock from the primary or the secondary source. Three domain-level selects then each choose the shared system clock, the secondary source directly, or nothing. Each domain has its own 4-bit divider and emits one reference-cycle pulse for every (field + 1) strobes of its selected source. The CPU and cache domains sit behind the CPU select. The bus-2 and peripheral domains sit behind the bus-2 select.

Software drives the block through a small write/read register bus. A divider field takes effect only when a write also sets the change-enable bit of its group (CPU group, bus-0 group, bus-2 group). The new ratio is loaded at the old divider's next terminal count, so no pulse period is cut short. A per-group busy flag covers the window from the write until the new ratio is in use. Every select also has a settle flag. The flag drops when the select field changes and rises again after two strobes of the newly selected source. Software polls these status bits before it relies on a new setting.

Top module: `clk_muxdiv_ctrl`

## Requirements
- R1: After reset the control register reads 0x00000055 (every select field = 1, every divider = 0, every change-enable = 0), the status register reads 0x0000000F (all settle bits 1, all busy bits 0), and no domain pulse is driven.
- R2: A select field value of 1 picks the primary strobe (source select, bits 1:0) or the shared system clock (domain selects at bits 3:2 CPU, 5:4 bus 0, 7:6 bus 2). A value of 2 picks the secondary strobe. A value of 0 or 3 gives no strobe, so the domains behind it emit no pulses.
- R3: Domain pulse outputs dom_ce_o bit 0 CPU, 1 cache, 2 bus 0, 3 bus 2 and 4 peripheral each rise for one cycle, one cycle after every (D+1)-th strobe of the domain's source. D is the active divider value.
- R4: The divider fields (bits 11:8 CPU, 15:12 cache, 19:16 bus 0, 23:20 bus 2, 27:24 peripheral) are stored and read back on every control write. They change the active ratio only for groups whose change-enable bit (28 CPU and cache, 29 bus 0, 30 bus 2) is set in that same write. A write without the bit leaves the busy flag at 0 and the pulse spacing unchanged.
- R5: An accepted divider write sets its group's busy bit (status bit 4 CPU, 5 bus 0, 6 bus 2) at that write. The bit stays set until all dividers of the group use the new ratio, and clears one cycle later.
- R6: A pending ratio is loaded on the next terminal count of the old ratio, and counting restarts from zero. A further accepted write while a ratio is pending replaces the pending value.
- R7: A control write that changes a select field clears that select's settle bit (status bit 0 source, 1 CPU, 2 bus 0, 3 bus 2). The bit is set again after two strobes of the newly selected source. A write that leaves the field unchanged does not touch the bit.
- R8: The CPU and cache domains follow the CPU select, and the bus-2 and peripheral domains follow the bus-2 select. With equal dividers, each pair pulses in the same cycles.
- R9: Writes to the status address (1) have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_stb_i | input | 1 | Primary source strobe, one reference cycle per source edge |
| sec_stb_i | input | 1 | Secondary source strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 status |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| dom_ce_o | output | 5 | Per-domain clock-enable pulses |

## Verification
The divider datapath runs with a primary strobe on every other cycle and a pseudo-random secondary strobe. The spacing of each domain's pulses is therefore checked against both a regular and an irregular source. A behavioural model is compared every cycle through accepted divider writes, writes without change-enable, and two accepted writes in a row while a ratio is still pending. These cases separate an immediate load from a load at terminal count, and a replaced pending value from the first one. Select changes cover the secondary source, a source that produces nothing, and a rewrite of an unchanged field. The rewrite shows whether the settle bits react only to real changes. Paired-domain equality and writes to the read-only status address complete the set.

// File: rtl/cmd_pkg.sv
`timescale 1ns/1ps
package cmd_pkg;
  // Structural counts of the clock tree
  localparam int N_DOM = 5;   // cpu, cache, bus0, bus2, periph
  localparam int N_MUX = 4;   // source, cpu, bus0, bus2
  localparam int N_GRP = 3;   // cpu group, bus0 group, bus2 group

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Divider group of each domain; group g is fed by select g+1
  function automatic int dom_grp(input int d);
    case (d)
      0, 1:    return 0;
      2:       return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/cmd_srcmux.sv
`timescale 1ns/1ps
module cmd_srcmux #(
  parameter int SEL_W = 2,
  parameter int N_MUX = 4
) (
  input  logic [N_MUX*SEL_W-1:0] sel_i,
  input  logic                   pri_i,
  input  logic                   sec_i,
  output logic [N_MUX-1:0]       stb_o
);
  function automatic logic pick(input logic [SEL_W-1:0] s, input logic a, input logic b);
    if (s == SEL_W'(1))      return a;
    else if (s == SEL_W'(2)) return b;
    else                     return 1'b0;
  endfunction

  logic base_stb;
  assign base_stb = pick(sel_i[0 +: SEL_W], pri_i, sec_i);
  assign stb_o[0] = base_stb;

  for (genvar i = 1; i < N_MUX; i++) begin : g_dom_mux
    assign stb_o[i] = pick(sel_i[i*SEL_W +: SEL_W], base_stb, sec_i);
  end
endmodule

// File: rtl/cmd_divider.sv
`timescale 1ns/1ps
module cmd_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             accept_i,
  input  logic [DIV_W-1:0] tgt_i,
  output logic             ce_o,
  output logic             pend_o
);
  logic [DIV_W-1:0] cnt_q, act_q, tgt_q;
  logic             pend_q, ce_q;
  logic             term;

  assign term = stb_i && (cnt_q == act_q);

  // count strobes; ratio swap only at the old terminal count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      ce_q <= term;
      if (term) begin
        cnt_q <= '0;
        if (pend_q) act_q <= tgt_q;
      end else if (stb_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      pend_q <= 1'b0;
    end else if (accept_i) begin
      tgt_q  <= tgt_i;
      pend_q <= 1'b1;
    end else if (term) begin
      pend_q <= 1'b0;
    end
  end

  assign ce_o   = ce_q;
  assign pend_o = pend_q;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q);
  assert_swap_at_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(stb_i && !accept_i));
  assert_pulse_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> $past(stb_i));
endmodule

// File: rtl/cmd_regs.sv
`timescale 1ns/1ps
module cmd_regs
  import cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 2,
  parameter int DIV_W      = 4,
  parameter int SETTLE_CNT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic                   wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  input  logic [N_MUX-1:0]       mux_stb_i,
  input  logic [N_DOM-1:0]       dom_pend_i,
  output logic [N_MUX*SEL_W-1:0] sel_o,
  output logic [N_DOM-1:0]       accept_o,
  output logic [N_DOM*DIV_W-1:0] tgt_o
);
  localparam int DIV_LSB = N_MUX * SEL_W;
  localparam int CE_LSB  = DIV_LSB + N_DOM * DIV_W;
  localparam int SCW     = $clog2(SETTLE_CNT + 1);

  function automatic logic [DATA_W-1:0] ctrl_reset();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_MUX; i++) v[i*SEL_W +: SEL_W] = SEL_W'(1);
    return v;
  endfunction
  localparam logic [DATA_W-1:0] CTRL_RST = ctrl_reset();

  logic [DATA_W-1:0]  ctrl_q;
  logic [N_GRP-1:0]   busy_q, grp_acc, grp_pend;
  logic [N_MUX-1:0]   done_q, sel_chg;
  logic [SCW-1:0]     sc_q [N_MUX];
  logic               ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= wr_data_i;
  end

  assign sel_o = ctrl_q[0 +: N_MUX*SEL_W];

  // divider group acceptance and busy tracking
  always_comb begin
    grp_pend = '0;
    for (int d = 0; d < N_DOM; d++) grp_pend[dom_grp(d)] = grp_pend[dom_grp(d)] | dom_pend_i[d];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_acc[g] = ctrl_wr && wr_data_i[CE_LSB+g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_q[g] <= 1'b0;
      else if (grp_acc[g]) busy_q[g] <= 1'b1;
      else                 busy_q[g] <= busy_q[g] && grp_pend[g];
    end

    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q[g]) |-> $past(ctrl_wr && wr_data_i[CE_LSB+g]));
    assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q[g]) |-> !$past(grp_pend[g]));
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign accept_o[d]              = grp_acc[dom_grp(d)];
    assign tgt_o[d*DIV_W +: DIV_W]  = wr_data_i[DIV_LSB + d*DIV_W +: DIV_W];
  end

  // select settle tracking
  for (genvar i = 0; i < N_MUX; i++) begin : g_mux
    assign sel_chg[i] = ctrl_wr &&
      (wr_data_i[i*SEL_W +: SEL_W] != ctrl_q[i*SEL_W +: SEL_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[i] <= 1'b1;
        sc_q[i]   <= '0;
      end else if (sel_chg[i]) begin
        done_q[i] <= 1'b0;
        sc_q[i]   <= '0;
      end else if (!done_q[i] && mux_stb_i[i]) begin
        if (sc_q[i] == SCW'(SETTLE_CNT - 1)) done_q[i] <= 1'b1;
        else                                 sc_q[i]   <= sc_q[i] + 1'b1;
      end
    end

    assert_settle_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q[i]) |-> $past(ctrl_wr));
    assert_settle_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[i]) |-> $past(mux_stb_i[i]));
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_STAT) begin
      rd_data_o[N_MUX-1:0]       = done_q;
      rd_data_o[N_MUX +: N_GRP]  = busy_q;
    end else begin
      rd_data_o = ctrl_q;
    end
  end

  assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/clk_muxdiv_ctrl.sv
`timescale 1ns/1ps
module clk_muxdiv_ctrl
  import cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 2,
  parameter int DIV_W      = 4,
  parameter int SETTLE_CNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_stb_i,
  input  logic              sec_stb_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_DOM-1:0]  dom_ce_o
);
  logic [N_MUX*SEL_W-1:0] sel;
  logic [N_MUX-1:0]       mux_stb;
  logic [N_DOM-1:0]       accept, pend;
  logic [N_DOM*DIV_W-1:0] tgt;

  cmd_regs #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .DIV_W(DIV_W), .SETTLE_CNT(SETTLE_CNT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .mux_stb_i(mux_stb), .dom_pend_i(pend),
    .sel_o(sel), .accept_o(accept), .tgt_o(tgt)
  );

  cmd_srcmux #(.SEL_W(SEL_W), .N_MUX(N_MUX)) u_mux (
    .sel_i(sel), .pri_i(pri_stb_i), .sec_i(sec_stb_i), .stb_o(mux_stb)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_div
    cmd_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n),
      .stb_i(mux_stb[dom_grp(d) + 1]),
      .accept_i(accept[d]),
      .tgt_i(tgt[d*DIV_W +: DIV_W]),
      .ce_o(dom_ce_o[d]),
      .pend_o(pend[d])
    );
  end

  // R8: domains sharing one select see the same strobe
  assert_pair_share_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (g_div[0].u_div.cnt_q == g_div[1].u_div.cnt_q &&
     g_div[0].u_div.act_q == g_div[1].u_div.act_q) |=>
     (dom_ce_o[0] == dom_ce_o[1]));
endmodule

// File: tb/sim_clk_muxdiv_ctrl.sv
`timescale 1ns/1ps
module sim_clk_muxdiv_ctrl;
  localparam int P  = 8;
  localparam int QT = P / 4;
  localparam int WD = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pri = 1'b0, sec = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  dom_ce;

  int checks = 0, fails = 0;
  bit fin = 0;

  always #(P/2) clk = ~clk;

  clk_muxdiv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pri_stb_i(pri), .sec_stb_i(sec),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .dom_ce_o(dom_ce)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt[5], m_act[5], m_tgt[5], m_pend[5], m_ce[5];
  int m_busy[3], m_done[4], m_sc[4];
  logic [31:0] m_ctrl;

  function automatic int grp(input int d);
    return (d < 2) ? 0 : (d == 2) ? 1 : 2;
  endfunction

  function automatic int fsel(input logic [31:0] c, input int i);
    return int'((c >> (2*i)) & 32'h3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 5; d++) begin
        m_cnt[d] = 0; m_act[d] = 0; m_tgt[d] = 0; m_pend[d] = 0; m_ce[d] = 0;
      end
      for (int g = 0; g < 3; g++) m_busy[g] = 0;
      for (int i = 0; i < 4; i++) begin m_done[i] = 1; m_sc[i] = 0; end
      m_ctrl = 32'h55;
    end else begin
      int ms[4];
      int gp[3];
      int acc[3];
      bit wrc;
      int base;
      wrc = wr_en && (wr_addr == 1'b0);
      base = (fsel(m_ctrl,0) == 1) ? int'(pri) : (fsel(m_ctrl,0) == 2) ? int'(sec) : 0;
      ms[0] = base;
      for (int i = 1; i < 4; i++)
        ms[i] = (fsel(m_ctrl,i) == 1) ? base : (fsel(m_ctrl,i) == 2) ? int'(sec) : 0;
      for (int g = 0; g < 3; g++) begin
        gp[g] = 0;
        acc[g] = (wrc && wr_data[28+g]) ? 1 : 0;
      end
      for (int d = 0; d < 5; d++) if (m_pend[d] != 0) gp[grp(d)] = 1;
      for (int g = 0; g < 3; g++)
        m_busy[g] = (acc[g] != 0) ? 1 : ((m_busy[g] != 0 && gp[g] != 0) ? 1 : 0);
      for (int d = 0; d < 5; d++) begin
        int s, t;
        s = ms[grp(d) + 1];
        t = (s != 0 && m_cnt[d] == m_act[d]) ? 1 : 0;
        m_ce[d] = t;
        if (t != 0) begin
          m_cnt[d] = 0;
          if (m_pend[d] != 0) m_act[d] = m_tgt[d];
        end else if (s != 0) m_cnt[d]++;
        if (acc[grp(d)] != 0) begin
          m_tgt[d] = int'((wr_data >> (8 + 4*d)) & 32'hF);
          m_pend[d] = 1;
        end else if (t != 0) m_pend[d] = 0;
      end
      for (int i = 0; i < 4; i++) begin
        if (wrc && fsel(wr_data,i) != fsel(m_ctrl,i)) begin
          m_done[i] = 0; m_sc[i] = 0;
        end else if (m_done[i] == 0 && ms[i] != 0) begin
          if (m_sc[i] == 1) m_done[i] = 1;
          else m_sc[i]++;
        end
      end
      if (wrc) m_ctrl = wr_data;
    end
  end

  function automatic logic [31:0] m_stat();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 4; i++) v[i] = (m_done[i] != 0);
    for (int g = 0; g < 3; g++) v[4+g] = (m_busy[g] != 0);
    return v;
  endfunction

  function automatic logic [4:0] m_cev();
    logic [4:0] v;
    for (int d = 0; d < 5; d++) v[d] = (m_ce[d] != 0);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(dom_ce == m_cev(), "R2 R3 R6 R8 domain pulses", {27'd0, dom_ce}, {27'd0, m_cev()});
      if (rd_addr) chk(rd_data == m_stat(), "R5 R7 status", rd_data, m_stat());
      else         chk(rd_data == m_ctrl, "R4 R9 control readback", rd_data, m_ctrl);
    end
  end

  // ---------------- source strobes ----------------
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk); #(QT);
      lfsr = {lfsr[0], lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      cyc++;
      pri = (cyc % 2) == 0;
      sec = lfsr[2] | lfsr[7];
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #(QT); end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(posedge clk); #(QT);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #(QT);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    rd_addr = 1'b1; #1;
    while (rd_data[6:4] != 3'b000 && n < 200) begin idle(1); #1; n++; end
    chk(rd_data[6:4] == 3'b000, tag, {29'd0, rd_data[6:4]}, 32'd0);
  endtask

  task automatic wait_settled(input string tag);
    int n;
    n = 0;
    rd_addr = 1'b1; #1;
    while (rd_data[3:0] != 4'hF && n < 200) begin idle(1); #1; n++; end
    chk(rd_data[3:0] == 4'hF, tag, {28'd0, rd_data[3:0]}, 32'hF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WD) @(posedge clk);
    if (!fin) begin
      fin = 1;
      checks++; fails++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #(QT); rst_n = 1'b1;
    // R1 reset state
    rd_addr = 1'b0; #1;
    chk(rd_data == 32'h55, "R1 control after reset", rd_data, 32'h55);
    rd_addr = 1'b1; #1;
    chk(rd_data == 32'h0F, "R1 status after reset", rd_data, 32'h0F);
    chk(dom_ce == 5'd0, "R1 pulses after reset", {27'd0, dom_ce}, 32'd0);
    idle(40);

    // R5 accepted change on CPU and bus-2 groups
    wr(1'b0, 32'h5041_3255); #1;
    chk(rd_data[6:4] == 3'b101, "R5 busy set on accept", {29'd0, rd_data[6:4]}, 32'h5);
    wait_idle("R5 busy clears after apply");
    wr(1'b0, 32'h0041_3255);
    idle(60);

    // R4 divider write without change-enable
    wr(1'b0, 32'h0041_3755); #1;
    chk(rd_data[6:4] == 3'b000, "R4 no busy without enable", {29'd0, rd_data[6:4]}, 32'd0);
    rd_addr = 1'b0; #1;
    chk(rd_data == 32'h0041_3755, "R4 field stored", rd_data, 32'h0041_3755);
    rd_addr = 1'b1;
    idle(40);
    wr(1'b0, 32'h1041_3755);
    wait_idle("R6 CPU ratio applied");
    wr(1'b0, 32'h0041_3755);
    idle(30);

    // R8 CPU select on secondary, all dividers to zero
    wr(1'b0, 32'h7000_0059);
    wait_idle("R8 zero ratios applied");
    wr(1'b0, 32'h0000_0059);
    idle(10);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (dom_ce[0] != dom_ce[1] || dom_ce[3] != dom_ce[4]) cnt++;
      idle(1);
    end
    chk(cnt == 0, "R8 paired domains pulse together", cnt, 0);

    // R7 unchanged field leaves settle bits, changed field clears one
    wait_settled("R7 settled before rewrite");
    wr(1'b0, 32'h0000_0059); #1;
    chk(rd_data[3:0] == 4'hF, "R7 same-value write", {28'd0, rd_data[3:0]}, 32'hF);
    wr(1'b0, 32'h0000_0055); #1;
    chk(rd_data[3:0] == 4'hD, "R7 CPU select change", {28'd0, rd_data[3:0]}, 32'hD);
    wait_settled("R7 settle bit returns");

    // R2 source select with no clock
    wr(1'b0, 32'h0000_0054);
    idle(3);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      #1;
      if (dom_ce != 5'd0) cnt++;
      idle(1);
    end
    chk(cnt == 0, "R2 no pulses from empty source", cnt, 0);
    wr(1'b0, 32'h0000_0055);
    idle(20);

    // R9 write to status address
    wr(1'b1, 32'hFFFF_FFFF);
    rd_addr = 1'b0; #1;
    chk(rd_data == 32'h55, "R9 control untouched", rd_data, 32'h55);
    rd_addr = 1'b1; #1;
    chk(rd_data == 32'h0F, "R9 status untouched", rd_data, 32'h0F);

    // R2/R6 secondary source, back-to-back accepted writes
    wr(1'b0, 32'h0000_0056);
    idle(40);
    wr(1'b0, 32'h7321_5456);
    idle(5);
    wr(1'b0, 32'h7000_0056);
    idle(80);
    wait_idle("R6 replaced pending ratio applied");
    wr(1'b0, 32'h0000_0056);
    idle(30);

    fin = 1;
    summary();
    $finish;
  end
endmodule